// File: doc/BRIEF.md
# Programmable FIFO Threshold Flag Generator

This block turns a FIFO occupancy count into two registered level flags. The high-water flag `hi_flag` warns that the FIFO is filling up. The low-water flag `lo_flag` warns that it is draining. The count comes from FIFO logic elsewhere in the design and is sampled on every clock edge. Both flags are registered, so each one reflects the count and the levels that were present at the previous rising edge.

Each flag has its own integer mode parameter with four settings:

- **0:** a single level fixed at elaboration.
- **1:** a single level read from an input port.
- **2:** a set level and a release level, both fixed at elaboration, giving hysteresis.
- **3:** a set level and a release level, both read from input ports.

In the port-driven modes the levels can be moved while the FIFO runs. In the fixed modes the level ports have no effect.

Internally, every mode reduces to a pair of set and release levels. In single-level mode the two are equal. One hysteresis core per flag then compares the count against that pair.

Top module: `thr_flag_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `hi_flag` becomes 0 and `lo_flag` becomes 1, whatever the count and levels are.
- R2: With `HI_MODE` = 0, `hi_flag` after an edge is 1 when `occ` ≥ `HI_ONE` at that edge, and 0 otherwise. The default `HI_ONE` is 12.
- R3: With `HI_MODE` = 1, `hi_flag` after an edge is 1 when `occ` ≥ `hi_one_lvl` at that edge, and 0 otherwise.
- R4: With `HI_MODE` = 2, `hi_flag` becomes 1 at any edge where `occ` ≥ `HI_SET`. The default `HI_SET` is 13.
- R5: With `HI_MODE` = 2, when `occ` is below `HI_SET`:
  - `hi_flag` becomes 0 when `occ` < `HI_CLR` (default 9).
  - Otherwise `hi_flag` keeps its previous value.
- R6: With `LO_MODE` = 0 or 1, `lo_flag` after an edge is 1 when `occ` ≤ the single level, and 0 otherwise. The single level is `LO_ONE` (default 4) in mode 0 and `lo_one_lvl` in mode 1.
- R7: With `LO_MODE` = 2, `lo_flag` responds as follows:
  - It becomes 1 when `occ` ≤ `LO_SET` (default 3).
  - Otherwise it becomes 0 when `occ` > `LO_CLR` (default 5).
  - Otherwise it holds its previous value.
- R8: With mode 3, each flag follows the hysteresis rule of R4, R5 and R7, using its level ports. The ports are `hi_set_lvl`/`hi_clr_lvl` and `lo_set_lvl`/`lo_clr_lvl`. A change to those ports takes effect at the next edge. In the fixed modes 0 and 2, the level ports have no effect on the flag.
- R9: Each flag has one cycle of latency. A count change applied between edges is not visible on a flag until after the next rising edge.
- R10: If port-driven levels conflict, the set condition takes priority over the release condition. A conflict means a release level at or above the set level for `hi_flag`, or at or below it for `lo_flag`.
- R11: The mode encoding is 0 for a fixed single level, 1 for a port single level, 2 for a fixed set/release pair and 3 for a port set/release pair. This encoding applies to `HI_MODE` and `LO_MODE` alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| occ | input | CNT_W | FIFO occupancy count |
| hi_one_lvl | input | CNT_W | Single high-water level (mode 1) |
| hi_set_lvl | input | CNT_W | High-water set level (mode 3) |
| hi_clr_lvl | input | CNT_W | High-water release level (mode 3) |
| lo_one_lvl | input | CNT_W | Single low-water level (mode 1) |
| lo_set_lvl | input | CNT_W | Low-water set level (mode 3) |
| lo_clr_lvl | input | CNT_W | Low-water release level (mode 3) |
| hi_flag | output | 1 | Registered programmable-full flag |
| lo_flag | output | 1 | Registered programmable-empty flag |

## Verification
On every cycle out of reset, the assertions check the hysteresis rule inside each core against the resolved level pair. They cover setting, releasing and holding, with set priority, for both flag polarities.

Only the bench scenarios can show the rest:
- that each mode resolves to the right source, fixed parameter or port;
- that the level ports are ignored in the fixed modes;
- the reset values;
- the one-cycle latency seen at the ports.

The bench does this by running four instances, one per mode, side by side against a reference model.

// File: rtl/thr_flag_pkg.sv
// Package: shared mode encoding for the threshold flag generator.
// Assumes: mode parameters are restricted to the four values below (R11).
package thr_flag_pkg;
    localparam int MODE_FIX_ONE  = 0;
    localparam int MODE_PORT_ONE = 1;
    localparam int MODE_FIX_PAIR = 2;
    localparam int MODE_PORT_PAIR = 3;

    // True when the mode takes its levels from ports.
    function automatic bit mode_is_port(input int mode);
        return (mode == MODE_PORT_ONE) || (mode == MODE_PORT_PAIR);
    endfunction
endpackage

// File: rtl/thr_level_sel.sv
// Module: thr_level_sel
// Resolves one flag's set and release levels from its mode. A single-level
// mode drives the same value on both outputs, so the downstream hysteresis
// core behaves as a plain compare. Fixed modes ignore the level ports.
// Assumes: MODE is one of the thr_flag_pkg encodings.
module thr_level_sel
    import thr_flag_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int MODE    = MODE_PORT_PAIR,
    parameter int FIX_ONE = 12,
    parameter int FIX_SET = 13,
    parameter int FIX_CLR = 9
) (
    input  logic [CNT_W-1:0] one_lvl,
    input  logic [CNT_W-1:0] set_lvl_in,
    input  logic [CNT_W-1:0] clr_lvl_in,
    output logic [CNT_W-1:0] set_lvl,
    output logic [CNT_W-1:0] clr_lvl
);
    localparam logic [CNT_W-1:0] K_ONE = CNT_W'(FIX_ONE);
    localparam logic [CNT_W-1:0] K_SET = CNT_W'(FIX_SET);
    localparam logic [CNT_W-1:0] K_CLR = CNT_W'(FIX_CLR);

    // Pick the level source selected by the elaboration-time mode.
    always_comb begin
        case (MODE)
            MODE_FIX_ONE: begin
                set_lvl = K_ONE;
                clr_lvl = K_ONE;
            end
            MODE_PORT_ONE: begin
                set_lvl = one_lvl;
                clr_lvl = one_lvl;
            end
            MODE_FIX_PAIR: begin
                set_lvl = K_SET;
                clr_lvl = K_CLR;
            end
            default: begin
                set_lvl = set_lvl_in;
                clr_lvl = clr_lvl_in;
            end
        endcase
    end
endmodule

// File: rtl/thr_hyst_flag.sv
// Module: thr_hyst_flag
// Registered hysteresis flag. HIGH_SIDE=1: sets when count >= set level,
// releases when count < release level. HIGH_SIDE=0: sets when count <=
// set level, releases when count > release level. Set wins over release;
// if neither holds the flag keeps its value.
// Assumes: synchronous active-low reset loads RST_VAL.
module thr_hyst_flag #(
    parameter int CNT_W     = 10,
    parameter bit HIGH_SIDE = 1'b1,
    parameter bit RST_VAL   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] set_lvl,
    input  logic [CNT_W-1:0] clr_lvl,
    output logic             flag
);
    logic hit_set;
    logic hit_clr;

    // Compare the count against both levels in the direction of this flag.
    always_comb begin
        if (HIGH_SIDE) begin
            hit_set = (occ >= set_lvl);
            hit_clr = (occ < clr_lvl);
        end else begin
            hit_set = (occ <= set_lvl);
            hit_clr = (occ > clr_lvl);
        end
    end

    // Flag register: reset value, then set priority, then release, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= RST_VAL;
        else if (hit_set)  flag <= 1'b1;
        else if (hit_clr)  flag <= 1'b0;
    end

    generate
        if (HIGH_SIDE) begin : g_hi_chk
            // R4 / R10: reaching the set level raises the flag next cycle
            a_r4_hi_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (occ >= set_lvl) |=> flag);
            // R5: below the release level and below set drops the flag
            a_r5_hi_clears: assert property (@(posedge clk) disable iff (!rst_n)
                ((occ < clr_lvl) && (occ < set_lvl)) |=> !flag);
            // R5: inside the band the flag holds
            a_r5_hi_holds: assert property (@(posedge clk) disable iff (!rst_n)
                ((occ >= clr_lvl) && (occ < set_lvl)) |=> $stable(flag));
        end else begin : g_lo_chk
            // R7 / R10: at or below the set level raises the flag next cycle
            a_r7_lo_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (occ <= set_lvl) |=> flag);
            // R7: above the release level and above set drops the flag
            a_r7_lo_clears: assert property (@(posedge clk) disable iff (!rst_n)
                ((occ > clr_lvl) && (occ > set_lvl)) |=> !flag);
            // R7: inside the band the flag holds
            a_r7_lo_holds: assert property (@(posedge clk) disable iff (!rst_n)
                ((occ <= clr_lvl) && (occ > set_lvl)) |=> $stable(flag));
        end
    endgenerate
endmodule

// File: rtl/thr_flag_gen.sv
// Module: thr_flag_gen (top)
// Produces registered programmable-full (hi_flag) and programmable-empty
// (lo_flag) flags from a FIFO occupancy count. Each flag has its own mode
// (R11 encoding in thr_flag_pkg). Reset clears hi_flag and sets lo_flag.
// Assumes: occ is a synchronous count in the clk domain.
module thr_flag_gen
    import thr_flag_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int HI_MODE = MODE_PORT_PAIR,
    parameter int LO_MODE = MODE_PORT_PAIR,
    parameter int HI_ONE  = 12,
    parameter int HI_SET  = 13,
    parameter int HI_CLR  = 9,
    parameter int LO_ONE  = 4,
    parameter int LO_SET  = 3,
    parameter int LO_CLR  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] hi_one_lvl,
    input  logic [CNT_W-1:0] hi_set_lvl,
    input  logic [CNT_W-1:0] hi_clr_lvl,
    input  logic [CNT_W-1:0] lo_one_lvl,
    input  logic [CNT_W-1:0] lo_set_lvl,
    input  logic [CNT_W-1:0] lo_clr_lvl,
    output logic             hi_flag,
    output logic             lo_flag
);
    logic [CNT_W-1:0] hi_set_r;
    logic [CNT_W-1:0] hi_clr_r;
    logic [CNT_W-1:0] lo_set_r;
    logic [CNT_W-1:0] lo_clr_r;

    // Level resolution for the high-water flag.
    thr_level_sel #(
        .CNT_W(CNT_W), .MODE(HI_MODE),
        .FIX_ONE(HI_ONE), .FIX_SET(HI_SET), .FIX_CLR(HI_CLR)
    ) u_hi_sel (
        .one_lvl(hi_one_lvl), .set_lvl_in(hi_set_lvl), .clr_lvl_in(hi_clr_lvl),
        .set_lvl(hi_set_r), .clr_lvl(hi_clr_r)
    );

    // Level resolution for the low-water flag.
    thr_level_sel #(
        .CNT_W(CNT_W), .MODE(LO_MODE),
        .FIX_ONE(LO_ONE), .FIX_SET(LO_SET), .FIX_CLR(LO_CLR)
    ) u_lo_sel (
        .one_lvl(lo_one_lvl), .set_lvl_in(lo_set_lvl), .clr_lvl_in(lo_clr_lvl),
        .set_lvl(lo_set_r), .clr_lvl(lo_clr_r)
    );

    // High-water hysteresis core, reset low.
    thr_hyst_flag #(.CNT_W(CNT_W), .HIGH_SIDE(1'b1), .RST_VAL(1'b0)) u_hi_flag (
        .clk(clk), .rst_n(rst_n), .occ(occ),
        .set_lvl(hi_set_r), .clr_lvl(hi_clr_r), .flag(hi_flag)
    );

    // Low-water hysteresis core, reset high.
    thr_hyst_flag #(.CNT_W(CNT_W), .HIGH_SIDE(1'b0), .RST_VAL(1'b1)) u_lo_flag (
        .clk(clk), .rst_n(rst_n), .occ(occ),
        .set_lvl(lo_set_r), .clr_lvl(lo_clr_r), .flag(lo_flag)
    );
endmodule

// File: tb/thr_flag_gen_test.sv
// Bench: four instances (one per mode, R11) share stimulus; a bench model
// predicts each flag after every rising edge.
module thr_flag_gen_test;
    localparam int PERIOD = 10;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] occ = '0;
    logic [W-1:0] hi_one = 10'd12, hi_set = 10'd13, hi_clr = 10'd9;
    logic [W-1:0] lo_one = 10'd4, lo_set = 10'd3, lo_clr = 10'd5;
    logic hi_o [4];
    logic lo_o [4];
    logic hi_m [4];
    logic lo_m [4];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    // index = mode for both flags
    thr_flag_gen #(.CNT_W(W), .HI_MODE(3), .LO_MODE(3)) uut (
        .clk(clk), .rst_n(rst_n), .occ(occ), .hi_one_lvl(hi_one), .hi_set_lvl(hi_set),
        .hi_clr_lvl(hi_clr), .lo_one_lvl(lo_one), .lo_set_lvl(lo_set), .lo_clr_lvl(lo_clr),
        .hi_flag(hi_o[3]), .lo_flag(lo_o[3]));
    thr_flag_gen #(.CNT_W(W), .HI_MODE(0), .LO_MODE(0)) uut_m0 (
        .clk(clk), .rst_n(rst_n), .occ(occ), .hi_one_lvl(hi_one), .hi_set_lvl(hi_set),
        .hi_clr_lvl(hi_clr), .lo_one_lvl(lo_one), .lo_set_lvl(lo_set), .lo_clr_lvl(lo_clr),
        .hi_flag(hi_o[0]), .lo_flag(lo_o[0]));
    thr_flag_gen #(.CNT_W(W), .HI_MODE(1), .LO_MODE(1)) uut_m1 (
        .clk(clk), .rst_n(rst_n), .occ(occ), .hi_one_lvl(hi_one), .hi_set_lvl(hi_set),
        .hi_clr_lvl(hi_clr), .lo_one_lvl(lo_one), .lo_set_lvl(lo_set), .lo_clr_lvl(lo_clr),
        .hi_flag(hi_o[1]), .lo_flag(lo_o[1]));
    thr_flag_gen #(.CNT_W(W), .HI_MODE(2), .LO_MODE(2)) uut_m2 (
        .clk(clk), .rst_n(rst_n), .occ(occ), .hi_one_lvl(hi_one), .hi_set_lvl(hi_set),
        .hi_clr_lvl(hi_clr), .lo_one_lvl(lo_one), .lo_set_lvl(lo_set), .lo_clr_lvl(lo_clr),
        .hi_flag(hi_o[2]), .lo_flag(lo_o[2]));

    function automatic logic next_hi(logic cur, int c, int s, int r);
        if (c >= s) return 1'b1;
        if (c < r) return 1'b0;
        return cur;
    endfunction

    function automatic logic next_lo(logic cur, int c, int s, int r);
        if (c <= s) return 1'b1;
        if (c > r) return 1'b0;
        return cur;
    endfunction

    function automatic string hi_tag(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4 R5";
            default: return "R8";
        endcase
    endfunction

    function automatic string lo_tag(int m);
        case (m)
            0, 1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (occ=%0d)", tag, act, exp, occ);
        end
    endtask

    // Advance model for levels applied this cycle (R11 mode per index).
    task automatic model_edge();
        for (int m = 0; m < 4; m++) begin
            int hs, hc, ls, lc;
            case (m)
                0: begin hs = 12; hc = 12; ls = 4; lc = 4; end
                1: begin hs = int'(hi_one); hc = int'(hi_one); ls = int'(lo_one); lc = int'(lo_one); end
                2: begin hs = 13; hc = 9; ls = 3; lc = 5; end
                default: begin hs = int'(hi_set); hc = int'(hi_clr); ls = int'(lo_set); lc = int'(lo_clr); end
            endcase
            hi_m[m] = next_hi(hi_m[m], int'(occ), hs, hc);
            lo_m[m] = next_lo(lo_m[m], int'(occ), ls, lc);
        end
    endtask

    // Inputs are already applied (at a negedge); take one edge and compare.
    task automatic step(string extra);
        @(posedge clk);
        model_edge();
        #1;
        for (int m = 0; m < 4; m++) begin
            check({hi_tag(m), extra}, hi_o[m], hi_m[m]);
            check({lo_tag(m), extra}, lo_o[m], lo_m[m]);
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int m = 0; m < 4; m++) begin hi_m[m] = 1'b0; lo_m[m] = 1'b1; end
        // R1: reset with a count that would set hi and clear lo
        occ = 10'd20;
        repeat (2) @(posedge clk);
        #1;
        for (int m = 0; m < 4; m++) begin
            check("R1", hi_o[m], 1'b0);
            check("R1", lo_o[m], 1'b1);
        end
        @(negedge clk);
        rst_n = 1'b1;
        occ = 10'd0;
        step("");

        // R4 R5 R7: sweep up then down through both bands
        for (int v = 0; v <= 16; v++) begin occ = W'(v); step(" sweep-up"); end
        for (int v = 16; v >= 0; v--) begin occ = W'(v); step(" sweep-down"); end

        // R9: count change between edges is not visible until the next edge
        occ = 10'd12;
        #2;
        check("R9", hi_o[0], 1'b0);
        step(" R9");
        check("R9", hi_o[0], 1'b1);

        // R8: run-time level change on port modes; fixed modes ignore ports
        occ = 10'd7;
        step("");
        hi_one = 10'd6; hi_set = 10'd7; hi_clr = 10'd2;
        lo_one = 10'd8; lo_set = 10'd8; lo_clr = 10'd10;
        step(" R8-change");
        check("R8", hi_o[3], 1'b1);
        check("R8 fixed ignores port", hi_o[0], 1'b0);
        check("R8 fixed ignores port", lo_o[2], 1'b0);

        // R10: conflicting port levels, set wins
        hi_set = 10'd5; hi_clr = 10'd8; lo_set = 10'd8; lo_clr = 10'd6;
        occ = 10'd6;
        step(" R10");
        check("R10", hi_o[3], 1'b1);
        check("R10", lo_o[3], 1'b1);

        // Constrained random walk on count, occasional level changes
        hi_one = 10'd12; hi_set = 10'd13; hi_clr = 10'd9;
        lo_one = 10'd4; lo_set = 10'd3; lo_clr = 10'd5;
        for (int i = 0; i < 3000; i++) begin
            int v;
            if (i % 60 == 59) begin
                int a;
                a = $urandom_range(3, 18);
                hi_one = W'(a);
                hi_set = W'(a);
                hi_clr = W'($urandom_range(2, a - 1));
                a = $urandom_range(2, 12);
                lo_one = W'(a);
                lo_set = W'(a);
                lo_clr = W'($urandom_range(a + 1, 20));
            end
            v = int'(occ) + int'($urandom_range(0, 4)) - 2;
            if (v < 0) v = 0;
            if (v > 24) v = 24;
            occ = W'(v);
            step(" random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule